// File: doc/BRIEF.md
# Descriptor List Stream Position Tracker

This block follows one audio stream as its data moves through a buffer descriptor list held in memory. Each descriptor names a 64-bit buffer address, a byte length and a flag that asks for a completion interrupt. The block fetches one descriptor at a time through a simple request/response port, hands out the memory address of every 4-byte word the data path moves, and counts how far the stream has gone. The word counter ("link position") wraps at a programmed cyclic buffer length.

Each time the position changes, the block emits a single write pulse. The pulse carries two register offsets for the position: the stream's own position register and an alias 0x2000 above it. When the position buffer is enabled, it also carries a memory address for the copy. Finishing a flagged descriptor sets a sticky completion status bit. Software clears that bit by writing one to it.

Stream control arrives as three fields: a reset bit, a run bit and a 4-bit stream tag. A stream reset clears all state. A rising run bit restarts the walk at descriptor 0 with position 0. A falling run bit stops the walk.

Top module: `bdl_pos_tracker`

## Requirements
- R1: After chip reset, and in the cycle after `ctl_srst` is seen high, the following are all zero: position, entry index, byte offset, completion status, `word_rdy` and `desc_req`. Holding `ctl_srst` also sets `srst_q` and `sts_fifordy`. `sts_fifordy` stays set after `ctl_srst` falls.
- R2: The cycle after a rising `ctl_run` (with `ctl_srst` low), the block raises `desc_req` with `desc_addr` equal to `bdl_base`. A descriptor for index i is always requested at `bdl_base + 16*i`.
- R3: While `word_rdy` is high, `word_addr` equals the current descriptor's buffer address plus the byte offset within it. Each accepted `word_stb` adds 4 to the offset and to `lpib`.
- R4: When an accepted word brings the byte offset to the descriptor length, the offset returns to 0. In the next cycle `desc_req` asks for the following index.
- R5: After the descriptor whose index equals `lvi` completes, the next request is for index 0.
- R6: Completing a descriptor whose flag is set sets `sts_bcis`. The bit holds until a cycle with `sts_clr_bcis` high clears it. If a set and a clear fall in the same cycle, the set wins.
- R7: When `cbl` is non-zero and the advanced position would reach `cbl`, `lpib` becomes 0 instead.
- R8: `pos_wr` pulses for one cycle with `lpib` already holding the new value. For the default stream index 5, `pos_reg_off` is 0x124, which is 0x80 + 32*5 + 4. `pos_alias_off` is that offset plus 0x2000. `pos_mem_wr` accompanies `pos_wr` only when `pib_en` is high, and `pos_mem_addr` is `pib_base + 8*5`.
- R9: `word_stb` is ignored when `word_rdy` is low, which is the case while stopped or while a descriptor fetch is pending. Position and offset are unchanged.
- R10: `stream_tag` is captured from `ctl_tag` on the run rise. `is_out` is 1 when the stream index is 4 or more.
- R11: The cycle after `ctl_run` is seen low, `word_rdy` and `desc_req` are low and `lpib` holds its value.
- R12: A run rise sets `lpib` to 0 and pulses `pos_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_srst | input | 1 | Stream reset control bit |
| ctl_run | input | 1 | Stream run control bit |
| ctl_tag | input | 4 | Stream tag field of the control word |
| bdl_base | input | 64 | Descriptor list base address |
| lvi | input | 8 | Index of the last valid descriptor |
| cbl | input | 32 | Cyclic buffer length in bytes (0 disables wrap) |
| pib_en | input | 1 | Position buffer copy enable |
| pib_base | input | 64 | Position buffer base address |
| sts_clr_bcis | input | 1 | Write-one-to-clear pulse for completion status |
| word_stb | input | 1 | One 4-byte word transferred |
| desc_vld | input | 1 | Descriptor fetch response valid |
| desc_buf_addr | input | 64 | Fetched descriptor buffer address |
| desc_len | input | 32 | Fetched descriptor length in bytes |
| desc_ioc | input | 1 | Fetched descriptor completion flag |
| desc_req | output | 1 | Descriptor fetch request |
| desc_addr | output | 64 | Address of requested descriptor |
| word_rdy | output | 1 | Block accepts word strobes |
| word_addr | output | 64 | Memory address of the next word |
| lpib | output | 32 | Link position in buffer |
| pos_wr | output | 1 | Position write pulse |
| pos_reg_off | output | 16 | Register offset of position |
| pos_alias_off | output | 16 | Register offset of position alias |
| pos_mem_wr | output | 1 | Position buffer memory write |
| pos_mem_addr | output | 64 | Position buffer memory address |
| stream_tag | output | 4 | Captured stream tag |
| is_out | output | 1 | Stream is an output stream |
| sts_bcis | output | 1 | Buffer completion status |
| sts_fifordy | output | 1 | FIFO-ready status |
| srst_q | output | 1 | Stream reset readback |

## Verification
The hardest situation to reach is the completion of the last valid descriptor, which has to be followed by a fetch of index 0. Reaching it takes a full walk of every descriptor, counting words exactly. The bench holds a small descriptor table and answers each fetch itself. It walks all three entries, then checks the address of the fourth request. It also lines up a clear pulse with the final word of a flagged descriptor to check that the set wins, and it issues strobes while a fetch is left unanswered.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH  = 2'd1,
    ST_ACTIVE = 2'd2
  } bpt_state_e;

  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned DESC_BYTES = 16;
endpackage

// File: rtl/bpt_ctrl.sv
module bpt_ctrl
  import bpt_pkg::*;
#(
  parameter int unsigned TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst_i,
  input  logic             run_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             word_stb_i,
  input  logic             desc_vld_i,
  input  logic             entry_done_i,
  output bpt_state_e       state_o,
  output logic             run_rise_o,
  output logic             accept_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             srst_o,
  output logic             fifordy_o
);
  bpt_state_e       state_q, state_d;
  logic             run_q;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             fifordy_q, fifordy_d;
  logic             srst_q;
  logic             tag_en;

  assign run_rise_o = run_i & ~run_q & ~srst_i;
  assign accept_o   = word_stb_i & run_i & ~srst_i & (state_q == ST_ACTIVE);
  assign tag_en     = srst_i | run_rise_o;

  always_comb begin
    state_d   = state_q;
    tag_d     = tag_q;
    fifordy_d = fifordy_q | srst_i;
    if (srst_i) begin
      state_d = ST_IDLE;
      tag_d   = '0;
    end else if (run_rise_o) begin
      state_d = ST_FETCH;
      tag_d   = tag_i;
    end else if (!run_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_FETCH:  if (desc_vld_i)   state_d = ST_ACTIVE;
        ST_ACTIVE: if (entry_done_i) state_d = ST_FETCH;
        default:   state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      run_q     <= 1'b0;
      tag_q     <= '0;
      fifordy_q <= 1'b0;
      srst_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      run_q     <= run_i;
      srst_q    <= srst_i;
      fifordy_q <= fifordy_d;
      if (tag_en) tag_q <= tag_d;
    end
  end

  assign state_o   = state_q;
  assign tag_o     = tag_q;
  assign srst_o    = srst_q;
  assign fifordy_o = fifordy_q;

  // R11
  run_drop_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i) |=> (state_q == ST_IDLE));

  // R1
  srst_fifordy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_i |=> (fifordy_q && srst_q && state_q == ST_IDLE));
endmodule

// File: rtl/bpt_walker.sv
module bpt_walker
  import bpt_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LEN_W  = 32,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst_i,
  input  logic              run_rise_i,
  input  logic              accept_i,
  input  logic              fetch_i,
  input  logic              active_i,
  input  logic              desc_vld_i,
  input  logic [ADDR_W-1:0] desc_buf_addr_i,
  input  logic [LEN_W-1:0]  desc_len_i,
  input  logic              desc_ioc_i,
  input  logic [ADDR_W-1:0] bdl_base_i,
  input  logic [IDX_W-1:0]  lvi_i,
  input  logic [LEN_W-1:0]  cbl_i,
  input  logic              bcis_clr_i,
  output logic              entry_done_o,
  output logic [ADDR_W-1:0] desc_addr_o,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic [LEN_W-1:0]  lpib_o,
  output logic              bcis_o,
  output logic              pos_wr_o
);
  localparam int unsigned DESC_SH = $clog2(DESC_BYTES);
  localparam logic [LEN_W-1:0] STEP = LEN_W'(WORD_BYTES);

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [LEN_W-1:0]  off_q, off_d, off_inc;
  logic [LEN_W-1:0]  lpib_q, lpib_d, lpib_inc;
  logic [ADDR_W-1:0] buf_q;
  logic [LEN_W-1:0]  len_q;
  logic              ioc_q;
  logic              bcis_q, bcis_d;
  logic              pos_wr_q, pos_wr_d;
  logic              walk_en, desc_en, set_bcis;

  assign off_inc      = off_q + STEP;
  assign lpib_inc     = lpib_q + STEP;
  assign entry_done_o = accept_i & (off_inc >= len_q);
  assign set_bcis     = entry_done_o & ioc_q;
  assign walk_en      = srst_i | run_rise_i | accept_i;
  assign desc_en      = srst_i | (fetch_i & desc_vld_i & ~run_rise_i);

  always_comb begin
    idx_d    = idx_q;
    off_d    = off_q;
    lpib_d   = lpib_q;
    pos_wr_d = 1'b0;
    bcis_d   = bcis_q;
    if (srst_i) begin
      idx_d  = '0;
      off_d  = '0;
      lpib_d = '0;
      bcis_d = 1'b0;
    end else if (run_rise_i) begin
      idx_d    = '0;
      off_d    = '0;
      lpib_d   = '0;
      pos_wr_d = 1'b1;
      if (bcis_clr_i) bcis_d = 1'b0;
    end else begin
      if (bcis_clr_i) bcis_d = 1'b0;
      if (accept_i) begin
        pos_wr_d = 1'b1;
        lpib_d   = ((cbl_i != '0) && (lpib_inc >= cbl_i)) ? '0 : lpib_inc;
        if (entry_done_o) begin
          off_d = '0;
          idx_d = (idx_q == lvi_i) ? '0 : idx_q + IDX_W'(1);
        end else begin
          off_d = off_inc;
        end
      end
      if (set_bcis) bcis_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      off_q    <= '0;
      lpib_q   <= '0;
      bcis_q   <= 1'b0;
      pos_wr_q <= 1'b0;
      buf_q    <= '0;
      len_q    <= '0;
      ioc_q    <= 1'b0;
    end else begin
      pos_wr_q <= pos_wr_d;
      bcis_q   <= bcis_d;
      if (walk_en) begin
        idx_q  <= idx_d;
        off_q  <= off_d;
        lpib_q <= lpib_d;
      end
      if (desc_en) begin
        buf_q <= srst_i ? '0 : desc_buf_addr_i;
        len_q <= srst_i ? '0 : desc_len_i;
        ioc_q <= srst_i ? 1'b0 : desc_ioc_i;
      end
    end
  end

  assign desc_addr_o = bdl_base_i + (ADDR_W'(idx_q) << DESC_SH);
  assign word_addr_o = buf_q + ADDR_W'(off_q);
  assign lpib_o      = lpib_q;
  assign bcis_o      = bcis_q;
  assign pos_wr_o    = pos_wr_q;

  // R1
  srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_i |=> (lpib_q == '0 && idx_q == '0 && off_q == '0 && !bcis_q));

  // R3
  off_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> (off_q[1:0] == 2'b00 && off_q < len_q));

  // R5
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i || fetch_i) |-> (idx_q <= lvi_i));

  // R6
  bcis_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bcis_q) |-> $past(accept_i && ioc_q));

  // R7
  lpib_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && cbl_i != '0) |-> (lpib_q < cbl_i));
endmodule

// File: rtl/bpt_mirror.sv
module bpt_mirror #(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned OFS_W      = 16,
  parameter int unsigned STREAM_IDX = 5,
  parameter int unsigned NUM_IN     = 4,
  parameter int unsigned SD_BASE    = 'h80,
  parameter int unsigned SD_STRIDE  = 32,
  parameter int unsigned LPIB_OFS   = 4,
  parameter int unsigned ALIAS_OFS  = 'h2000,
  parameter int unsigned PIB_STRIDE = 8
) (
  input  logic              pos_wr_i,
  input  logic              pib_en_i,
  input  logic [ADDR_W-1:0] pib_base_i,
  output logic [OFS_W-1:0]  reg_off_o,
  output logic [OFS_W-1:0]  alias_off_o,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              is_out_o
);
  localparam int unsigned REG_OFS = SD_BASE + STREAM_IDX * SD_STRIDE + LPIB_OFS;
  localparam int unsigned PIB_OFS = STREAM_IDX * PIB_STRIDE;

  assign reg_off_o   = OFS_W'(REG_OFS);
  assign alias_off_o = OFS_W'(REG_OFS + ALIAS_OFS);
  assign mem_wr_o    = pos_wr_i & pib_en_i;
  assign mem_addr_o  = pib_base_i + ADDR_W'(PIB_OFS);

  generate
    if (STREAM_IDX >= NUM_IN) begin : g_out
      assign is_out_o = 1'b1;
    end else begin : g_in
      assign is_out_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/bdl_pos_tracker.sv
module bdl_pos_tracker
  import bpt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned LEN_W      = 32,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned TAG_W      = 4,
  parameter int unsigned OFS_W      = 16,
  parameter int unsigned STREAM_IDX = 5,
  parameter int unsigned NUM_IN     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_srst,
  input  logic              ctl_run,
  input  logic [TAG_W-1:0]  ctl_tag,
  input  logic [ADDR_W-1:0] bdl_base,
  input  logic [IDX_W-1:0]  lvi,
  input  logic [LEN_W-1:0]  cbl,
  input  logic              pib_en,
  input  logic [ADDR_W-1:0] pib_base,
  input  logic              sts_clr_bcis,
  input  logic              word_stb,
  input  logic              desc_vld,
  input  logic [ADDR_W-1:0] desc_buf_addr,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic              desc_ioc,
  output logic              desc_req,
  output logic [ADDR_W-1:0] desc_addr,
  output logic              word_rdy,
  output logic [ADDR_W-1:0] word_addr,
  output logic [LEN_W-1:0]  lpib,
  output logic              pos_wr,
  output logic [OFS_W-1:0]  pos_reg_off,
  output logic [OFS_W-1:0]  pos_alias_off,
  output logic              pos_mem_wr,
  output logic [ADDR_W-1:0] pos_mem_addr,
  output logic [TAG_W-1:0]  stream_tag,
  output logic              is_out,
  output logic              sts_bcis,
  output logic              sts_fifordy,
  output logic              srst_q
);
  bpt_state_e state;
  logic       run_rise, accept, entry_done;
  logic       fetch, active;

  assign fetch    = (state == ST_FETCH);
  assign active   = (state == ST_ACTIVE);
  assign desc_req = fetch;
  assign word_rdy = active;

  bpt_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .srst_i       (ctl_srst),
    .run_i        (ctl_run),
    .tag_i        (ctl_tag),
    .word_stb_i   (word_stb),
    .desc_vld_i   (desc_vld),
    .entry_done_i (entry_done),
    .state_o      (state),
    .run_rise_o   (run_rise),
    .accept_o     (accept),
    .tag_o        (stream_tag),
    .srst_o       (srst_q),
    .fifordy_o    (sts_fifordy)
  );

  bpt_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_walker (
    .clk             (clk),
    .rst_n           (rst_n),
    .srst_i          (ctl_srst),
    .run_rise_i      (run_rise),
    .accept_i        (accept),
    .fetch_i         (fetch),
    .active_i        (active),
    .desc_vld_i      (desc_vld),
    .desc_buf_addr_i (desc_buf_addr),
    .desc_len_i      (desc_len),
    .desc_ioc_i      (desc_ioc),
    .bdl_base_i      (bdl_base),
    .lvi_i           (lvi),
    .cbl_i           (cbl),
    .bcis_clr_i      (sts_clr_bcis),
    .entry_done_o    (entry_done),
    .desc_addr_o     (desc_addr),
    .word_addr_o     (word_addr),
    .lpib_o          (lpib),
    .bcis_o          (sts_bcis),
    .pos_wr_o        (pos_wr)
  );

  bpt_mirror #(
    .ADDR_W     (ADDR_W),
    .OFS_W      (OFS_W),
    .STREAM_IDX (STREAM_IDX),
    .NUM_IN     (NUM_IN)
  ) u_mirror (
    .pos_wr_i    (pos_wr),
    .pib_en_i    (pib_en),
    .pib_base_i  (pib_base),
    .reg_off_o   (pos_reg_off),
    .alias_off_o (pos_alias_off),
    .mem_wr_o    (pos_mem_wr),
    .mem_addr_o  (pos_mem_addr),
    .is_out_o    (is_out)
  );

  // R9
  stb_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && !word_rdy && !ctl_srst && !run_rise) |=> $stable(lpib));

  // R12
  pos_wr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_wr |-> $past((word_stb && word_rdy) || (ctl_run && !ctl_srst)));

  // R2
  fetch_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_rise |=> (desc_req && desc_addr == bdl_base));
endmodule

// File: tb/bdl_pos_tracker_tb.sv
module bdl_pos_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_srst = 1'b0, ctl_run = 1'b0;
  logic [3:0]  ctl_tag = '0;
  logic [63:0] bdl_base = '0, pib_base = '0;
  logic [7:0]  lvi = '0;
  logic [31:0] cbl = '0;
  logic        pib_en = 1'b0, sts_clr_bcis = 1'b0, word_stb = 1'b0;
  logic        desc_vld = 1'b0, desc_ioc = 1'b0;
  logic [63:0] desc_buf_addr = '0;
  logic [31:0] desc_len = '0;
  logic        desc_req, word_rdy, pos_wr, pos_mem_wr, is_out;
  logic        sts_bcis, sts_fifordy, srst_q;
  logic [63:0] desc_addr, word_addr, pos_mem_addr;
  logic [31:0] lpib;
  logic [15:0] pos_reg_off, pos_alias_off;
  logic [3:0]  stream_tag;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_lpib = '0;
  logic [63:0] tab_addr [3];
  logic [31:0] tab_len [3];
  logic        tab_ioc [3];

  always #10 clk = ~clk;

  bdl_pos_tracker u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic serve(input int i);
    chk(desc_req === 1'b1, "R4 desc_req", 64'(desc_req), 64'd1);
    chk(desc_addr === bdl_base + 64'(16 * i), "R2/R5 desc_addr", desc_addr,
        bdl_base + 64'(16 * i));
    desc_vld = 1'b1; desc_buf_addr = tab_addr[i];
    desc_len = tab_len[i]; desc_ioc = tab_ioc[i];
    tick;
    desc_vld = 1'b0;
    chk(word_rdy === 1'b1, "R3 word_rdy", 64'(word_rdy), 64'd1);
  endtask

  task automatic do_word(input logic [63:0] addr, input bit clr);
    chk(word_addr === addr, "R3 word_addr", word_addr, addr);
    word_stb = 1'b1; sts_clr_bcis = clr;
    tick;
    word_stb = 1'b0; sts_clr_bcis = 1'b0;
    exp_lpib = exp_lpib + 32'd4;
    if (cbl != 0 && exp_lpib >= cbl) exp_lpib = '0;
    chk(pos_wr === 1'b1, "R8 pos_wr", 64'(pos_wr), 64'd1);
    chk(lpib === exp_lpib, "R3/R7 lpib", 64'(lpib), 64'(exp_lpib));
  endtask

  task automatic walk_entry(input int i, input bit clr_last);
    serve(i);
    for (int w = 0; w < int'(tab_len[i] / 4); w++)
      do_word(tab_addr[i] + 64'(4 * w), clr_last && (w == int'(tab_len[i] / 4) - 1));
    if (tab_ioc[i])
      chk(sts_bcis === 1'b1, "R6 bcis set", 64'(sts_bcis), 64'd1);
  endtask

  task automatic t_reset;
    chk(lpib === '0, "R1 lpib", 64'(lpib), 0);
    chk(word_rdy === 1'b0 && desc_req === 1'b0, "R1 idle", 64'({word_rdy, desc_req}), 0);
    chk(sts_bcis === 1'b0 && sts_fifordy === 1'b0 && srst_q === 1'b0, "R1 status",
        64'({sts_bcis, sts_fifordy, srst_q}), 0);
  endtask

  task automatic t_srst;
    ctl_srst = 1'b1; tick;
    chk(srst_q === 1'b1 && sts_fifordy === 1'b1, "R1 srst bits",
        64'({srst_q, sts_fifordy}), 64'd3);
    ctl_srst = 1'b0; tick;
    chk(srst_q === 1'b0 && sts_fifordy === 1'b1, "R1 fifordy holds",
        64'({srst_q, sts_fifordy}), 64'd1);
  endtask

  task automatic t_walk;
    bdl_base = 64'h0000_0001_0000_0000; lvi = 8'd2; cbl = '0;
    pib_en = 1'b1; pib_base = 64'h8000; ctl_tag = 4'h9;
    ctl_run = 1'b1; tick; exp_lpib = '0;
    chk(pos_wr === 1'b1 && lpib === '0, "R12 start pos", 64'(lpib), 0);
    chk(stream_tag === 4'h9 && is_out === 1'b1, "R10 tag/dir",
        64'({is_out, stream_tag}), 64'h19);
    chk(pos_reg_off === 16'h0124 && pos_alias_off === 16'h2124, "R8 offsets",
        64'({pos_reg_off, pos_alias_off}), 64'h0124_2124);
    chk(pos_mem_wr === 1'b1 && pos_mem_addr === 64'h8028, "R8 mem copy",
        pos_mem_addr, 64'h8028);
    ctl_tag = 4'h3;
    walk_entry(0, 1'b0);
    chk(sts_bcis === 1'b0, "R6 no flag", 64'(sts_bcis), 0);
    walk_entry(1, 1'b0);
    walk_entry(2, 1'b0);
    chk(sts_bcis === 1'b1 && stream_tag === 4'h9, "R6/R10 hold",
        64'({sts_bcis, stream_tag}), 64'h19);
    walk_entry(0, 1'b0);
    sts_clr_bcis = 1'b1; tick; sts_clr_bcis = 1'b0;
    chk(sts_bcis === 1'b0, "R6 clear", 64'(sts_bcis), 0);
    ctl_run = 1'b0; tick;
    chk(word_rdy === 1'b0 && desc_req === 1'b0, "R11 stopped",
        64'({word_rdy, desc_req}), 0);
    word_stb = 1'b1; tick; word_stb = 1'b0;
    chk(lpib === exp_lpib, "R9 stopped stb", 64'(lpib), 64'(exp_lpib));
  endtask

  task automatic t_fetch_ignore;
    ctl_run = 1'b1; tick; exp_lpib = '0;
    word_stb = 1'b1; tick; word_stb = 1'b0;
    chk(lpib === '0 && desc_req === 1'b1, "R9 fetch stb", 64'(lpib), 0);
    serve(0);
    do_word(tab_addr[0], 1'b0);
  endtask

  task automatic t_cbl_wrap;
    ctl_run = 1'b0; tick;
    cbl = 32'd16; ctl_run = 1'b1; tick; exp_lpib = '0;
    walk_entry(0, 1'b0);
    walk_entry(1, 1'b1);
    chk(lpib === 32'd4, "R7 wrapped", 64'(lpib), 64'd4);
  endtask

  task automatic t_pib_off;
    pib_en = 1'b0;
    serve(2);
    do_word(tab_addr[2], 1'b0);
    chk(pos_mem_wr === 1'b0, "R8 pib off", 64'(pos_mem_wr), 0);
    ctl_srst = 1'b1; tick;
    chk(lpib === '0 && word_rdy === 1'b0 && sts_bcis === 1'b0, "R1 srst running",
        64'({lpib, word_rdy, sts_bcis}), 0);
    ctl_srst = 1'b0; ctl_run = 1'b0; tick;
  endtask

  initial begin
    tab_addr[0] = 64'h1000; tab_len[0] = 32'd8;  tab_ioc[0] = 1'b0;
    tab_addr[1] = 64'h2000; tab_len[1] = 32'd12; tab_ioc[1] = 1'b1;
    tab_addr[2] = 64'h3000; tab_len[2] = 32'd4;  tab_ioc[2] = 1'b0;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    t_reset;
    t_srst;
    t_walk;
    t_fetch_ignore;
    t_cbl_wrap;
    t_pib_off;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule